// File: doc/BRIEF.md
# MDIO Management Access Register

This block lets a host run single IEEE 802.3 clause-22 management transactions on a PHY's MDC/MDIO pair through one 32-bit word. The host writes a command word that holds a go flag, a direction flag, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. When the go flag is set, the engine sends the serial frame with MDC running. When the frame ends, the engine clears the go flag in the same word. On a read, it also places the value returned by the PHY in the low half of the word.

The host treats the go flag as busy. It polls the word until bit 31 reads 0, then takes bits 15:0 as the result of a read. The MDC rate is set by a parameter: each half of an MDC period lasts `HALF_DIV` system clocks. MDC stays low whenever no transaction is running.

Top module: `mdio_acc_engine`

## Requirements
- R1: After reset, rd_data is 0x00000000, MDC is low, the MDIO output enable is low and the MDIO output is 1.
- R2: A write with bit 31 set, accepted while bit 31 reads 0, stores the whole word and starts a transaction. Bit 31 reads 1 from the next clock until the transaction completes.
- R3: A write with bit 31 clear stores the word and starts no transaction: MDC stays low and the output enable stays low.
- R4: Writes that arrive while bit 31 reads 1 are ignored and do not change the stored word.
- R5: The frame is sent MSB first and is 64 bits long, in this order: 32 ones; the start pattern 01; the opcode (01 when bit 30 is 1, a write; 10 when bit 30 is 0, a read); the PHY address from bits 25:21; the register address from bits 20:16. A write then sends turnaround 10 followed by the data from bits 15:0.
- R6: MDC is low for the first `HALF_DIV` clocks of each bit and high for the next `HALF_DIV` clocks. The MDIO output changes only on the clock edge at which MDC falls.
- R7: During a read, the output enable is high for the first 46 bits (preamble, start, opcode and addresses). It is low for the two turnaround bits and the 16 data bits.
- R8: During a read, the MDIO input is sampled on the system clock edge at which MDC rises, in each of the 16 data bits, MSB first. At completion, the sampled value appears in bits 15:0.
- R9: The transaction completes on the clock edge that ends the 64th bit. On that edge bit 31 clears, MDC and the output enable go low, bits 30:16 are kept, and a write also keeps bits 15:0.
- R10: The word 0xC0A09000 writes 0x9000 to register 0 of PHY 5 (frame tail 0x52829000). The word 0xC0C09000 does the same for PHY 6 (frame tail 0x53029000).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe for the access word |
| wr_data | input | 32 | Command word to store |
| rd_data | output | 32 | Current access word: busy flag, command fields, data or result |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Management data returned from the PHY |

## Verification
The bench holds a behavioural model of the access word and of the expected frame timing, and compares MDC, MDIO, the output enable and the access word against it on every clock.

The runs target the following cases, and what a faulty design would do in each:
- A write issued in the middle of a transaction. A design that accepted it would corrupt the command or restart the frame.
- Reads whose returned data is 0x8001 or 0xA5C3. A design that sampled on the wrong MDC edge, or shifted in the wrong order, would return a shifted or mirrored result.
- The two reset-PHY command words. Here the collected serial bits are compared against the known frame tails, which exposes a swapped opcode, an address field off by one bit, or a wrong turnaround.
- A plain store with the go flag clear. A design that started a frame on it would show MDC toggling.

// File: rtl/mdio_acc_pkg.sv
package mdio_acc_pkg;

  // Layout of the host access word; bit positions are decoded by software.
  typedef struct packed {
    logic       req;    // 31: go / busy
    logic       wr;     // 30: 1 = write, 0 = read
    logic [3:0] spare;  // 29:26
    logic [4:0] phy;    // 25:21
    logic [4:0] regad;  // 20:16
    logic [15:0] data;  // 15:0
  } acc_word_t;

  localparam int HDR_BITS  = 14;   // start + opcode + two addresses
  localparam int TA_BITS   = 2;
  localparam int DATA_BITS = 16;

  localparam logic [1:0] SOF_PAT = 2'b01;
  localparam logic [1:0] OP_WR   = 2'b01;
  localparam logic [1:0] OP_RD   = 2'b10;
  localparam logic [1:0] TA_WR   = 2'b10;
  localparam logic [1:0] TA_RD   = 2'b11;

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);

  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          half_end;

  assign half_end  = run && (cnt_q == CNT_LAST);
  assign rise_tick = half_end && !mdc_q;
  assign fall_tick = half_end && mdc_q;
  assign mdc       = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (half_end) begin
      cnt_d = '0;
      mdc_d = !mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter #(
  parameter int FRAME_W  = 64,
  parameter int TA_POS   = 46,
  parameter int DATA_POS = 48,
  parameter int DATA_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic               active,
  input  logic               is_read,
  input  logic               rise_tick,
  input  logic               fall_tick,
  input  logic               mdio_i,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic               done,
  output logic [DATA_W-1:0]  rdata
);

  localparam int IW = $clog2(FRAME_W + 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_W - 1);
  localparam logic [IW-1:0] TA_IDX   = IW'(TA_POS);
  localparam logic [IW-1:0] DATA_IDX = IW'(DATA_POS);

  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [IW-1:0]      bidx_q, bidx_d;
  logic [DATA_W-1:0]  cap_q, cap_d;
  logic               sh_en;

  assign sh_en   = load || (active && (fall_tick || rise_tick));
  assign mdio_o  = active ? sh_q[FRAME_W-1] : 1'b1;
  assign mdio_oe = active && (!is_read || (bidx_q < TA_IDX));
  assign done    = active && fall_tick && (bidx_q == LAST_IDX);
  assign rdata   = cap_q;

  always_comb begin
    sh_d   = sh_q;
    bidx_d = bidx_q;
    cap_d  = cap_q;
    if (load) begin
      sh_d   = frame_in;
      bidx_d = '0;
      cap_d  = '0;
    end else if (active) begin
      if (fall_tick) begin
        sh_d   = {sh_q[FRAME_W-2:0], 1'b1};
        bidx_d = bidx_q + 1'b1;
      end
      if (rise_tick && is_read && (bidx_q >= DATA_IDX)) begin
        cap_d = {cap_q[DATA_W-2:0], mdio_i};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      bidx_q <= '0;
      cap_q  <= '0;
    end else if (sh_en) begin
      sh_q   <= sh_d;
      bidx_q <= bidx_d;
      cap_q  <= cap_d;
    end
  end

endmodule

// File: rtl/mdio_acc_engine.sv
module mdio_acc_engine
  import mdio_acc_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int PRE_LEN  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  localparam int FRAME_W  = PRE_LEN + HDR_BITS + TA_BITS + DATA_BITS;
  localparam int TA_POS   = PRE_LEN + HDR_BITS;
  localparam int DATA_POS = TA_POS + TA_BITS;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  acc_word_t          acc_q, acc_d, wr_word;
  logic               acc_en, accept, start, busy, done;
  logic               rise_tick, fall_tick;
  logic [FRAME_W-1:0] frame_in;
  logic [DATA_BITS-1:0] cap;

  assign wr_word = acc_word_t'(wr_data);
  assign busy    = acc_q.req;
  assign accept  = wr_en && !busy;
  assign start   = accept && wr_word.req;
  assign acc_en  = accept || done;
  assign rd_data = acc_q;

  assign frame_in = {{PRE_LEN{1'b1}}, SOF_PAT,
                     wr_word.wr ? OP_WR : OP_RD,
                     wr_word.phy, wr_word.regad,
                     wr_word.wr ? TA_WR : TA_RD,
                     wr_word.data};

  always_comb begin
    acc_d = acc_q;
    if (accept) begin
      acc_d = wr_word;
    end else if (done) begin
      acc_d.req = 1'b0;
      if (!acc_q.wr) acc_d.data = cap;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  mdio_mdc_gen #(.HALF_DIV(HALF_DIV)) u_mdc (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .run       (busy),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_frame_shifter #(
    .FRAME_W  (FRAME_W),
    .TA_POS   (TA_POS),
    .DATA_POS (DATA_POS),
    .DATA_W   (DATA_BITS)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load      (start),
    .frame_in  (frame_in),
    .active    (busy),
    .is_read   (!acc_q.wr),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_i    (mdio_i),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .done      (done),
    .rdata     (cap)
  );

endmodule

// File: rtl/mdio_acc_chk.sv
module mdio_acc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[31] && !rd_data[31]) |=> rd_data[31]);            // R2

  AST_IDLE_NO_MDC: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[31] |-> !mdc);                                              // R3

  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[31] |-> !mdio_oe);                                          // R9

  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31] |=> $stable(rd_data[30:16]));                            // R4

  AST_WR_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[31] && rd_data[30]) |=> $stable(rd_data[15:0]));            // R9

  AST_MDIO_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> $stable(mdio_o));                                            // R6

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data[31]) |-> (!mdc && !mdio_oe));                          // R9

endmodule

bind mdio_acc_engine mdio_acc_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe)
);

// File: tb/mdio_acc_engine_tb.sv
module mdio_acc_engine_tb;

  localparam int H = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        mdio_i = 1'b1;
  logic [31:0] rd_data;
  logic        mdc, mdio_o, mdio_oe;

  int checks = 0;
  int errors = 0;

  // reference model state
  int          m_t = -1;
  logic [31:0] m_reg = '0;
  logic [15:0] m_cap = '0;
  logic [63:0] m_frame = '1;
  logic [15:0] phy_word = '0;
  logic [63:0] capt = '0;
  logic        prev_mdc = 1'b0;

  always #5 clk = !clk;

  mdio_acc_engine #(.HALF_DIV(H), .PRE_LEN(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  function automatic logic [63:0] mk_frame(input logic [31:0] w);
    return {32'hFFFF_FFFF, 2'b01, (w[30] ? 2'b01 : 2'b10), w[25:21], w[20:16], 2'b10, w[15:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic model_edge(input logic we, input logic [31:0] wd, input logic mi);
    int e, n;
    if (m_t >= 0) begin
      e = m_t + 1;
      n = e / (2*H);
      if ((e % (2*H)) == H && !m_reg[30] && n >= 48 && n < 64)
        m_cap = {m_cap[14:0], mi};
      if (e == 64*2*H) begin
        m_t = -1;
        m_reg[31] = 1'b0;
        if (!m_reg[30]) m_reg[15:0] = m_cap;
      end else begin
        m_t = e;
      end
    end else if (we) begin
      m_reg = wd;
      if (wd[31]) begin
        m_t = 0;
        m_cap = '0;
        m_frame = mk_frame(wd);
      end
    end
  endtask

  task automatic cyc();
    logic busy, e_mdc, e_oe, e_o;
    int n;
    @(posedge clk);
    model_edge(wr_en, wr_data, mdio_i);
    @(negedge clk);
    busy  = (m_t >= 0);
    n     = busy ? m_t / (2*H) : 0;
    e_mdc = busy && ((m_t % (2*H)) >= H);
    e_oe  = busy && (m_reg[30] || n < 46);
    e_o   = busy ? m_frame[63-n] : 1'b1;
    check("R2 access word", rd_data, m_reg);
    check("R6 mdc", {31'd0, mdc}, {31'd0, e_mdc});
    check("R7 output enable", {31'd0, mdio_oe}, {31'd0, e_oe});
    if (e_oe) check("R5 mdio bit", {31'd0, mdio_o}, {31'd0, e_o});
    if (mdc && !prev_mdc && mdio_oe) capt = {capt[62:0], mdio_o};
    prev_mdc = mdc;
    if (busy && !m_reg[30] && n >= 48) mdio_i = phy_word[63-n];
    else mdio_i = 1'b1;
  endtask

  task automatic do_write(input logic [31:0] wd);
    wr_en = 1'b1;
    wr_data = wd;
    cyc();
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  task automatic txn(input logic [31:0] wd, input bit poke);
    int guard = 0;
    do_write(wd);
    while (m_t >= 0 && guard < 400) begin
      if (poke && guard == 20) do_write(32'h0000_0000);  // ignored: R4
      else cyc();
      guard++;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset rd_data", rd_data, 32'h0);
    check("R1 reset mdc/oe/o", {29'd0, mdc, mdio_oe, mdio_o}, 32'h1);
    rst_n = 1'b1;
    repeat (4) cyc();

    // R10 + R4: PHY 5 reset write with an ignored mid-frame write
    capt = '0;
    txn(32'hC0A0_9000, 1'b1);
    check("R10 phy5 frame tail", capt[31:0], 32'h5282_9000);
    check("R10 phy5 preamble", capt[63:32], 32'hFFFF_FFFF);
    check("R9 write done word", rd_data, 32'h40A0_9000);
    repeat (3) cyc();

    capt = '0;
    txn(32'hC0C0_9000, 1'b0);
    check("R10 phy6 frame tail", capt[31:0], 32'h5302_9000);

    // R3: store without go flag
    do_write(32'h1234_5678);
    repeat (12) cyc();
    check("R3 stored word", rd_data, 32'h1234_5678);

    // R8: reads
    phy_word = 16'hA5C3;
    txn(32'h80C5_0000, 1'b0);
    check("R8 read result", rd_data, 32'h00C5_A5C3);
    phy_word = 16'h8001;
    txn(32'h83FF_0000, 1'b1);
    check("R8 read edge bits", rd_data, 32'h03FF_8001);
    check("R9 idle after read", {30'd0, mdc, mdio_oe}, 32'h0);

    // write with all-ones data to PHY 0
    capt = '0;
    txn(32'hC000_FFFF, 1'b0);
    check("R5 frame tail", capt[31:0], 32'h5002_FFFF);
    repeat (4) cyc();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule